// File: doc/BRIEF.md
# Configuration Register Serial Slave

This block is the two-wire serial slave that fronts a small configuration device. It samples the clock and data lines with the system clock and finds START and STOP on the synchronised lines. It matches one of two 7-bit addresses, chosen by a strap input. It then either streams out three registers or accepts one write byte. It drives the data line only to pull it low: the pad and its pull-up are outside the block.

A read returns these three bytes in a fixed order:

1. Stored register A.
2. Stored register B.
3. A snapshot of the 5-bit parallel input port. The snapshot is taken one clock after each START, so the value read back cannot change while the transfer is in progress.

A write carries a single byte. Its top two bits pick register A or B, and its low six bits are the new value. An accepted write leaves the block as a one-cycle request to a separate storage block. That storage block feeds the stored values back in on `reg_a` and `reg_b`.

Top module: `cfg_i2c_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bits clocked without a new START are not acknowledged.
- R2: The slave acknowledges address 7'b1001110 when `addr_sel`=1 and 7'b0110111 when `addr_sel`=0, and no other address. The address is followed by a direction bit: 1 means read, 0 means write.
- R3: The general call address 7'b0000000 is never acknowledged.
- R4: A read returns three bytes, most significant bit first, in this order: {2'b00,`reg_a`}, then {2'b00,`reg_b`}, then {3'b000,snapshot}. Each byte is followed by an acknowledge bit from the master.
- R5: A NACK from the master after any read byte ends the read, and the slave releases SDA. The next read transaction starts again at register A.
- R6: The snapshot is loaded from `port_in` on the first clock after START. Later changes of `port_in` during the transaction do not affect the value read.
- R7: In a write data byte, bits 7:6 select the target: 00 means A and 01 means B. The byte is acknowledged. After the acknowledge clock, `wr_pulse` is high for exactly one cycle, with `wr_sel` equal to bits 7:6 and `wr_data` equal to bits 5:0.
- R8: A write data byte with bits 7:6 equal to 10 or 11 is acknowledged, but no `wr_pulse` is issued.
- R9: A repeated START after a read byte begins a new address phase, so a write may follow a read in the same transaction.
- R10: `sda_oe` is high only during an acknowledge or a 0 data bit sent by the slave, and it changes only while SCL is low.
- R11: A second data byte in the same write is not acknowledged and issues no write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Address strap |
| port_in | input | 5 | Parallel input port |
| reg_a | input | 6 | Stored register A value |
| reg_b | input | 6 | Stored register B value |
| wr_pulse | output | 1 | One-cycle write request |
| wr_sel | output | 2 | Write target select bits |
| wr_data | output | 6 | Write value |

## Verification
A wrong state in the sequencer shows up on the data line within one bit time. The failure is either a missing or extra acknowledge, or a read bit of the wrong value, seen at the next SCL high. A wrong byte index or a stale snapshot corrupts a whole read byte. A decoding fault in the write path shows up as a write request with the wrong select or data, or a request that was not expected or is missing. The bench compares each write request against its queue on every clock.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] ADDR_SEL1 = 7'b1001110,
  parameter logic [6:0] ADDR_SEL0 = 7'b0110111,
  parameter int         PW        = 5,
  parameter int         RW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_sel,
  input  logic [PW-1:0] port_in,
  input  logic [RW-1:0] reg_a,
  input  logic [RW-1:0] reg_b,
  output logic          wr_pulse,
  output logic [1:0]    wr_sel,
  output logic [RW-1:0] wr_data
);
  localparam int LAST_IDX = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AHOLD, S_AACK, S_WDATA, S_WHOLD, S_WACK, S_RDATA
  } st_t;
  localparam st_t S_RACK = st_t'(3'd0);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       start_q;
  st_t        st;
  logic       in_rack;
  logic [2:0] cnt;
  logic [7:0] sr;
  logic [1:0] idx;
  logic       hit, rnw, mack;
  logic [PW-1:0] snap;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire start   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop    = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_r   = scl_s & ~scl_q;
  wire scl_f   = ~scl_s & scl_q;
  wire [6:0] my_addr = addr_sel ? ADDR_SEL1 : ADDR_SEL0;

  function automatic logic [7:0] rd_byte(input logic [1:0] i);
    case (i)
      2'd0:    rd_byte = {2'b00, reg_a};
      2'd1:    rd_byte = {2'b00, reg_b};
      default: rd_byte = {{(8-PW){1'b0}}, snap};
    endcase
  endfunction

  wire [7:0] nxt_byte = rd_byte(idx + 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      start_q <= 1'b0; snap <= '0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      start_q <= start;
      if (start_q) snap <= port_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; in_rack <= 1'b0; cnt <= '0; sr <= '0; idx <= '0;
      hit <= 1'b0; rnw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      wr_pulse <= 1'b0; wr_sel <= '0; wr_data <= '0;
    end else begin
      wr_pulse <= 1'b0;
      if (start) begin
        st <= S_ADDR; in_rack <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; in_rack <= 1'b0; sda_oe <= 1'b0;
      end else if (in_rack) begin
        if (scl_r) mack <= ~sda_s;
        if (scl_f) begin
          in_rack <= 1'b0;
          if (mack && idx != 2'(LAST_IDX)) begin
            idx <= idx + 2'd1; sr <= nxt_byte; sda_oe <= ~nxt_byte[7];
            cnt <= '0; st <= S_RDATA;
          end else begin
            st <= S_IDLE;
          end
        end
      end else begin
        case (st)
          S_ADDR, S_WDATA: if (scl_r) begin
            sr <= {sr[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (st == S_ADDR) begin
                hit <= (sr[6:0] == my_addr);
                rnw <= sda_s;
                st  <= S_AHOLD;
              end else begin
                st <= S_WHOLD;
              end
            end
          end
          S_AHOLD: if (scl_f) begin
            sda_oe <= hit;
            st <= hit ? S_AACK : S_IDLE;
          end
          S_AACK: if (scl_f) begin
            cnt <= '0;
            if (rnw) begin
              idx <= '0; sr <= rd_byte(2'd0); sda_oe <= ~rd_byte(2'd0)[7];
              st <= S_RDATA;
            end else begin
              sda_oe <= 1'b0; st <= S_WDATA;
            end
          end
          S_WHOLD: if (scl_f) begin
            sda_oe <= 1'b1; st <= S_WACK;
          end
          S_WACK: if (scl_f) begin
            sda_oe <= 1'b0;
            wr_pulse <= ~sr[7];
            wr_sel <= sr[7:6];
            wr_data <= sr[5:0];
            st <= S_IDLE;
          end
          S_RDATA: if (scl_f) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0; in_rack <= 1'b1;
            end else begin
              sr <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
              cnt <= cnt + 3'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));                          // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !in_rack) |-> !sda_oe);                               // R1
  AST_ADDR_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK && !in_rack) |-> sda_oe);                                // R2
  AST_RD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 2'(LAST_IDX));                                                  // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);                                               // R7
  AST_WR_VALID_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !wr_sel[1]);                                              // R8
endmodule

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic addr_sel = 1'b1;
  logic [4:0] port_in = '0;
  logic [5:0] reg_a = '0, reg_b = '0;
  logic sda_oe, wr_pulse;
  logic [1:0] wr_sel;
  logic [5:0] wr_data;
  wire sda_line = msda & ~sda_oe;

  int vecs = 0, errs = 0;
  logic [7:0] wq[$];
  logic oe_prev = 1'b0;
  localparam int Q = 20;

  always #2 clk = ~clk;

  cfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .port_in(port_in), .reg_a(reg_a), .reg_b(reg_b),
    .wr_pulse(wr_pulse), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (sda_oe != oe_prev) chk(!scl, "R10 oe change while SCL high", sda_oe, oe_prev);
    oe_prev = sda_oe;
    if (wr_pulse) begin
      if (wq.size() == 0) chk(1'b0, "R8 unexpected write request", {wr_sel, wr_data}, 0);
      else begin
        logic [7:0] e;
        e = wq.pop_front();
        chk({wr_sel, wr_data} == e, "R7 write request", {wr_sel, wr_data}, e);
      end
    end
  end

  always @(posedge clk) if (wr_pulse) begin
    if (wr_sel == 2'b00) reg_a <= wr_data;
    else if (wr_sel == 2'b01) reg_b <= wr_data;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_cyc(input logic mb, input logic exp_oe, input string tag);
    scl = 1'b0; wt(Q/2); msda = mb; wt(Q/2);
    scl = 1'b1; wt(Q/2);
    chk(sda_oe == exp_oe, tag, sda_oe, exp_oe);
    wt(Q/2);
  endtask

  task automatic start_c();
    scl = 1'b0; wt(Q/2); msda = 1'b1; wt(Q/2);
    scl = 1'b1; wt(Q); msda = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    scl = 1'b0; wt(Q/2); msda = 1'b0; wt(Q/2);
    scl = 1'b1; wt(Q); msda = 1'b1; wt(2*Q);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], 1'b0, "R10 slave idle during master bit");
    bit_cyc(1'b1, exp_ack, tag);
  endtask

  task automatic recv(input logic [7:0] e, input logic mack, input string tag);
    for (int i = 7; i >= 0; i--) bit_cyc(1'b1, ~e[i], tag);
    bit_cyc(~mack, 1'b0, "R10 released for master ack");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wt(5);
    chk(sda_oe == 1'b0 && wr_pulse == 1'b0, "R10 reset state", {sda_oe, wr_pulse}, 0);
    rst_n = 1'b1; wt(10);
    reg_a = 6'h2A; reg_b = 6'h15; port_in = 5'h13;

    // R4 R6 full read, port changes after snapshot
    start_c(); port_in = 5'h0C;
    send({7'b1001110, 1'b1}, 1'b1, "R2 ack own address sel=1");
    recv(8'h2A, 1'b1, "R4 byte A");
    recv(8'h15, 1'b1, "R4 byte B");
    recv(8'h13, 1'b0, "R6 snapshot byte");
    stop_c();

    // R7 write A and B
    start_c(); wq.push_back({2'b00, 6'h3F});
    send({7'b1001110, 1'b0}, 1'b1, "R2 ack write address");
    send({2'b00, 6'h3F}, 1'b1, "R7 ack write A");
    stop_c();
    chk(wq.size() == 0, "R7 write A issued", wq.size(), 0);
    start_c(); wq.push_back({2'b01, 6'h05});
    send({7'b1001110, 1'b0}, 1'b1, "R2 ack write address");
    send({2'b01, 6'h05}, 1'b1, "R7 ack write B");
    stop_c();
    chk(wq.size() == 0, "R7 write B issued", wq.size(), 0);
    start_c();
    send({7'b1001110, 1'b1}, 1'b1, "R2 ack read");
    recv(8'h3F, 1'b1, "R7 readback A");
    recv(8'h05, 1'b0, "R7 readback B");
    stop_c();

    // R8 invalid select
    start_c();
    send({7'b1001110, 1'b0}, 1'b1, "R2 ack");
    send(8'h81, 1'b1, "R8 ack sel 10");
    stop_c();
    start_c();
    send({7'b1001110, 1'b0}, 1'b1, "R2 ack");
    send(8'hC7, 1'b1, "R8 ack sel 11");
    stop_c();

    // R11 second data byte
    start_c(); wq.push_back({2'b00, 6'h11});
    send({7'b1001110, 1'b0}, 1'b1, "R2 ack");
    send(8'h11, 1'b1, "R7 ack first byte");
    send(8'h22, 1'b0, "R11 second byte not acked");
    stop_c();
    chk(wq.size() == 0 && reg_a == 6'h11, "R11 only first byte written", reg_a, 6'h11);

    // R2 R3 addressing
    addr_sel = 1'b0;
    start_c(); send({7'b1001110, 1'b1}, 1'b0, "R2 other address ignored"); stop_c();
    start_c(); send(8'h00, 1'b0, "R3 general call ignored"); stop_c();
    start_c();
    send({7'b0110111, 1'b1}, 1'b1, "R2 ack own address sel=0");
    recv(8'h11, 1'b0, "R4 byte A sel=0");
    stop_c();
    addr_sel = 1'b1;
    start_c(); send({7'b0110111, 1'b0}, 1'b0, "R2 sel=0 address ignored when sel=1"); stop_c();

    // R9 repeated start read then write
    start_c(); wq.push_back({2'b01, 6'h2C});
    send({7'b1001110, 1'b1}, 1'b1, "R9 ack read");
    recv(8'h11, 1'b0, "R9 byte A");
    start_c();
    send({7'b1001110, 1'b0}, 1'b1, "R9 ack write after repeated start");
    send({2'b01, 6'h2C}, 1'b1, "R9 ack data");
    stop_c();
    chk(wq.size() == 0 && reg_b == 6'h2C, "R9 write after read", reg_b, 6'h2C);

    // R5 early end then restart at A
    start_c();
    send({7'b1001110, 1'b1}, 1'b1, "R5 ack");
    recv(8'h11, 1'b1, "R5 byte A");
    recv(8'h2C, 1'b0, "R5 byte B then nack");
    bit_cyc(1'b1, 1'b0, "R5 released after nack");
    stop_c();
    start_c();
    send({7'b1001110, 1'b1}, 1'b1, "R5 ack");
    recv(8'h11, 1'b0, "R5 restart at A");
    stop_c();

    // R1 no start after stop
    send({7'b1001110, 1'b0}, 1'b0, "R1 no ack without START");
    stop_c();

    wt(10);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule